// File: doc/BRIEF.md
# Configurable Burst Address Sequencer

This block produces the word addresses of a synchronous burst read. A one-cycle `go` pulse loads a start address together with a small configuration: a length code, a wrap selector and a WAIT lead selector. After a fixed first-access latency, the block emits one word address per cycle with a valid strobe. A fixed-length burst ends by itself. A continuous burst keeps running until `halt` or a new `go` ends it.

The WAIT indication tells the consumer when the data stream is not ready. It can be released one cycle ahead of the data or in the same cycle as the data. When a non-wrapping sequence with a start address that is not 4-word aligned first steps over a 16-word row boundary, the block inserts a short stall. WAIT covers that stall.

The configuration is captured when `go` is seen. Changing the configuration inputs afterwards does not affect a burst that is already running.

Top module: `burst_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `word_vld`, `busy` and `wait_flag` are 0.
- R2: `len_sel` 3'b001, 3'b010 and 3'b011 give bursts of 4, 8 and 16 valid words. After the last word, `word_vld` and `busy` go low. Every other code, including the reserved ones, gives a continuous burst.
- R3: With `linear_mode`=0 and a fixed length L, word i of a burst that starts at S has address (S & ~(L-1)) | ((S+i) & (L-1)). The sequence wraps inside the aligned L-word block.
- R4: With `linear_mode`=1, or with any continuous code, word i has address S+i modulo 2^ADDR_W. The wrap setting has no effect on a continuous burst.
- R5: If `go` is sampled at clock edge E, the first valid word appears after edge E+FIRST_LAT+1. Later words follow on consecutive cycles unless an R7 stall applies.
- R6: With `wait_lead`=1, `wait_flag` is high in a cycle exactly when a word of the burst is still due and `word_vld` will be 0 in the next cycle. With `wait_lead`=0, `wait_flag` equals `busy & ~word_vld`.
- R7: A stall applies to a non-wrapping sequence (`linear_mode`=1 or continuous) whose start address has bits [1:0] not equal to 0. After the first word whose address bits [3:0] equal 15, and only if more words follow, STALL_CYC idle cycles are inserted. A 4-word-aligned start is never stalled.
- R8: If `halt` is sampled at edge H without `go`, then `word_vld`, `busy` and `wait_flag` are 0 after edge H+1 and remain 0 until a new `go`.
- R9: A `go` during a running burst aborts it and starts the new burst with R5 timing from that edge.
- R10: `len_sel`, `linear_mode`, `wait_lead` and `go_addr` are sampled only when `go` is high. Changing them during a burst does not alter its addresses, length or WAIT timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse; samples the address and configuration |
| go_addr | input | ADDR_W | Start word address |
| len_sel | input | 3 | Burst length code |
| linear_mode | input | 1 | 1: increment across the block boundary; 0: wrap inside the aligned block |
| wait_lead | input | 1 | 1: WAIT changes one cycle before data; 0: WAIT changes with data |
| halt | input | 1 | Synchronous terminate |
| word_addr | output | ADDR_W | Current word address |
| word_vld | output | 1 | Word address valid |
| busy | output | 1 | Burst in progress at the output |
| wait_flag | output | 1 | WAIT indication |

## Verification
All results are counted from the edge E that samples `go`. The `busy` output is due after E+1. The first word is due after E+FIRST_LAT+1, and each later word follows one cycle after the one before it. A stall shifts every later word by STALL_CYC cycles. In lead mode `wait_flag` already changes after E; in coincident mode it trails by one more cycle. For each burst, the bench builds a per-cycle table of the expected values from the start address, code and mode. It samples every output on the falling edge after each edge E+n and compares it with table entry n, so each result is checked in the exact cycle it is due. A halt is checked two edges after it is sampled.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int CNT_W = 5;

  typedef struct packed {
    logic             cont;
    logic [CNT_W-1:0] count;
    logic [3:0]       mask;
  } len_info_t;
endpackage

// File: rtl/bsq_len_decode.sv
module bsq_len_decode
  import bsq_pkg::*;
(
  input  logic [2:0] code,
  output len_info_t  info
);
  always_comb begin
    info = '{cont: 1'b1, count: '0, mask: 4'hF};
    case (code)
      3'b001: info = '{cont: 1'b0, count: CNT_W'(4),  mask: 4'h3};
      3'b010: info = '{cont: 1'b0, count: CNT_W'(8),  mask: 4'h7};
      3'b011: info = '{cont: 1'b0, count: CNT_W'(16), mask: 4'hF};
      default: info = '{cont: 1'b1, count: '0, mask: 4'hF};
    endcase
  end
endmodule

// File: rtl/bsq_next_addr.sv
module bsq_next_addr #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [3:0]        mask,
  input  logic              wrap_en,
  output logic [ADDR_W-1:0] nxt
);
  logic [3:0] low_inc;

  always_comb begin
    low_inc = cur[3:0] + 4'd1;
    if (wrap_en)
      nxt = {cur[ADDR_W-1:4], (cur[3:0] & ~mask) | (low_inc & mask)};
    else
      nxt = cur + ADDR_W'(1);
  end
endmodule

// File: rtl/bsq_core.sv
module bsq_core
  import bsq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int FIRST_LAT = 2,
  parameter int STALL_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  input  len_info_t         info,
  input  logic              linear_mode,
  input  logic              wait_lead,
  input  logic              halt,
  output logic              act,
  output logic              vld,
  output logic              act_d,
  output logic              vld_d,
  output logic              lead_d,
  output logic [ADDR_W-1:0] slot_addr
);
  localparam int LW = (FIRST_LAT > 1) ? $clog2(FIRST_LAT + 1) : 1;
  localparam int SW = (STALL_CYC > 0) ? $clog2(STALL_CYC + 1) : 1;

  logic              fin, fin_d;
  logic [ADDR_W-1:0] ptr, ptr_d, ptr_nxt, addr_d;
  logic [LW-1:0]     lat, lat_d;
  logic [SW-1:0]     stall, stall_d;
  logic [CNT_W-1:0]  left, left_d;
  logic              cont, cont_d, wrap, wrap_d, lead, crossed, crossed_d;
  logic              misal, misal_d;
  logic [3:0]        mask, mask_d;

  bsq_next_addr #(.ADDR_W(ADDR_W)) u_step (
    .cur(ptr), .mask(mask), .wrap_en(wrap), .nxt(ptr_nxt)
  );

  always_comb begin
    act_d = act;  vld_d = vld;  fin_d = fin;  ptr_d = ptr;
    addr_d = slot_addr;  lat_d = lat;  stall_d = stall;  left_d = left;
    cont_d = cont;  wrap_d = wrap;  mask_d = mask;  lead_d = lead;
    crossed_d = crossed;  misal_d = misal;
    if (go) begin
      act_d     = 1'b1;
      vld_d     = 1'b0;
      fin_d     = 1'b0;
      ptr_d     = go_addr;
      lat_d     = LW'(FIRST_LAT - 1);
      stall_d   = '0;
      left_d    = info.count;
      cont_d    = info.cont;
      wrap_d    = ~linear_mode & ~info.cont;
      mask_d    = info.mask;
      lead_d    = wait_lead;
      crossed_d = 1'b0;
      misal_d   = |go_addr[1:0];
    end else if (halt) begin
      act_d = 1'b0;  vld_d = 1'b0;  fin_d = 1'b0;
      lat_d = '0;    stall_d = '0;
    end else if (act) begin
      if (fin) begin
        act_d = 1'b0;  vld_d = 1'b0;  fin_d = 1'b0;
      end else if (lat != '0) begin
        lat_d = lat - LW'(1);
        vld_d = 1'b0;
      end else if (stall != '0) begin
        stall_d = stall - SW'(1);
        vld_d   = 1'b0;
      end else begin
        vld_d  = 1'b1;
        addr_d = ptr;
        ptr_d  = ptr_nxt;
        if (!cont) left_d = left - CNT_W'(1);
        if (!cont && left == CNT_W'(1)) begin
          fin_d = 1'b1;
        end else if (!wrap && misal && !crossed && ptr[3:0] == 4'hF) begin
          stall_d   = SW'(STALL_CYC);
          crossed_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;  vld <= 1'b0;  fin <= 1'b0;  ptr <= '0;
      slot_addr <= '0;  lat <= '0;  stall <= '0;  left <= '0;
      cont <= 1'b0;  wrap <= 1'b0;  mask <= '0;  lead <= 1'b1;
      crossed <= 1'b0;  misal <= 1'b0;
    end else begin
      act <= act_d;  vld <= vld_d;  fin <= fin_d;  ptr <= ptr_d;
      slot_addr <= addr_d;  lat <= lat_d;  stall <= stall_d;  left <= left_d;
      cont <= cont_d;  wrap <= wrap_d;  mask <= mask_d;  lead <= lead_d;
      crossed <= crossed_d;  misal <= misal_d;
    end
  end
endmodule

// File: rtl/bsq_out_stage.sv
module bsq_out_stage #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              vld,
  input  logic              act_d,
  input  logic              vld_d,
  input  logic              lead_d,
  input  logic [ADDR_W-1:0] slot_addr,
  output logic [ADDR_W-1:0] word_addr,
  output logic              word_vld,
  output logic              busy,
  output logic              wait_flag
);
  logic wait_early, wait_late;

  // lead mode looks one slot ahead; coincident mode mirrors the current slot
  assign wait_early = act_d & ~vld_d;
  assign wait_late  = act & ~vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_addr <= '0;
      word_vld  <= 1'b0;
      busy      <= 1'b0;
      wait_flag <= 1'b0;
    end else begin
      word_addr <= slot_addr;
      word_vld  <= vld;
      busy      <= act;
      wait_flag <= lead_d ? wait_early : wait_late;
    end
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int FIRST_LAT = 2,
  parameter int STALL_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [2:0]        len_sel,
  input  logic              linear_mode,
  input  logic              wait_lead,
  input  logic              halt,
  output logic [ADDR_W-1:0] word_addr,
  output logic              word_vld,
  output logic              busy,
  output logic              wait_flag
);
  len_info_t         info;
  logic              act, vld, act_d, vld_d, lead_d;
  logic [ADDR_W-1:0] slot_addr;

  bsq_len_decode u_dec (.code(len_sel), .info(info));

  bsq_core #(
    .ADDR_W(ADDR_W), .FIRST_LAT(FIRST_LAT), .STALL_CYC(STALL_CYC)
  ) u_core (
    .clk(clk), .rst(rst), .go(go), .go_addr(go_addr), .info(info),
    .linear_mode(linear_mode), .wait_lead(wait_lead), .halt(halt),
    .act(act), .vld(vld), .act_d(act_d), .vld_d(vld_d), .lead_d(lead_d),
    .slot_addr(slot_addr)
  );

  bsq_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .act(act), .vld(vld), .act_d(act_d),
    .vld_d(vld_d), .lead_d(lead_d), .slot_addr(slot_addr),
    .word_addr(word_addr), .word_vld(word_vld), .busy(busy),
    .wait_flag(wait_flag)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              go,
  input logic              halt,
  input logic [ADDR_W-1:0] word_addr,
  input logic              word_vld,
  input logic              busy,
  input logic              wait_flag
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!word_vld && !busy && !wait_flag));

  p_vld_in_burst_r2: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> busy);

  // R3 / R4: consecutive words either step by one or wrap to an aligned start
  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (word_vld && $past(word_vld) && !$past(go) && !$past(go, 2)) |->
      ((word_addr == $past(word_addr) + ADDR_W'(1)) ||
       (word_addr[1:0] == 2'b00 &&
        word_addr[ADDR_W-1:4] == $past(word_addr[ADDR_W-1:4]))));

  p_wait_in_burst_r6: assert property (@(posedge clk) disable iff (rst)
    wait_flag |-> (busy || $past(go)));

  p_halt_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (halt && !go) ##1 !go |=> (!word_vld && !busy));
endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .go(go), .halt(halt), .word_addr(word_addr),
  .word_vld(word_vld), .busy(busy), .wait_flag(wait_flag)
);

// File: tb/burst_seq_test.sv
`timescale 1ns/1ps
module burst_seq_test;
  localparam int AW = 16;
  localparam int LAT = 2;
  localparam int STL = 2;
  localparam int TN = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0, linear_mode = 1'b1, wait_lead = 1'b1, halt = 1'b0;
  logic [AW-1:0] go_addr = '0;
  logic [2:0] len_sel = 3'b001;
  logic [AW-1:0] word_addr;
  logic word_vld, busy, wait_flag;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  bit          ea [TN];
  bit          ev [TN];
  logic [AW-1:0] eaddr [TN];

  always #4 clk = ~clk;

  burst_seq #(.ADDR_W(AW), .FIRST_LAT(LAT), .STALL_CYC(STL)) uut (
    .clk(clk), .rst(rst), .go(go), .go_addr(go_addr), .len_sel(len_sel),
    .linear_mode(linear_mode), .wait_lead(wait_lead), .halt(halt),
    .word_addr(word_addr), .word_vld(word_vld), .busy(busy),
    .wait_flag(wait_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act_v,
                     input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // expected stage table, entry n = burst state in the cycle after edge E0+n
  task automatic build(input logic [AW-1:0] sa, input logic [2:0] code, input bit lin);
    int L, mask, n;
    bit cont, wrap, crossed;
    logic [AW-1:0] a;
    cont = 1'b0;
    case (code)
      3'b001: begin L = 4;  mask = 3;  end
      3'b010: begin L = 8;  mask = 7;  end
      3'b011: begin L = 16; mask = 15; end
      default: begin L = 1000; mask = 15; cont = 1'b1; end
    endcase
    wrap = !lin && !cont;
    for (int k = 0; k < TN; k++) begin ea[k] = 0; ev[k] = 0; eaddr[k] = '0; end
    n = 0;
    for (int k = 0; k < LAT; k++) begin ea[n] = 1; n++; end
    crossed = 1'b0;
    for (int i = 0; i < L && n < TN; i++) begin
      if (wrap) a = (sa & ~AW'(mask)) | ((sa + AW'(i)) & AW'(mask));
      else      a = sa + AW'(i);
      ea[n] = 1; ev[n] = 1; eaddr[n] = a; n++;
      if (!wrap && sa[1:0] != 2'b00 && !crossed && a[3:0] == 4'hF && i < L - 1) begin
        crossed = 1'b1;
        for (int s = 0; s < STL; s++) if (n < TN) begin ea[n] = 1; n++; end
      end
    end
  endtask

  task automatic run(input logic [AW-1:0] sa, input logic [2:0] code,
                     input bit lin, input bit lead, input int horizon);
    bit wrap;
    bit ew;
    wrap = !lin && (code == 3'b001 || code == 3'b010 || code == 3'b011);
    build(sa, code, lin);
    @(negedge clk);
    go = 1'b1; go_addr = sa; len_sel = code; linear_mode = lin; wait_lead = lead;
    @(negedge clk);
    // R10: scramble configuration after go was sampled
    go = 1'b0; go_addr = ~sa; len_sel = (code == 3'b001) ? 3'b011 : 3'b001;
    linear_mode = !lin; wait_lead = !lead;
    if (lead) chk(wait_flag == (ea[0] && !ev[0]), "R6 lead wait", wait_flag, 1);
    for (int n = 1; n < horizon; n++) begin
      @(negedge clk);
      chk(word_vld == ev[n-1], "R2 R5 R7 R10 valid", word_vld, ev[n-1]);
      chk(busy == ea[n-1], "R2 busy", busy, ea[n-1]);
      if (ev[n-1]) begin
        if (wrap) chk(word_addr == eaddr[n-1], "R3 R10 wrapped address", word_addr, eaddr[n-1]);
        else      chk(word_addr == eaddr[n-1], "R4 R10 linear address", word_addr, eaddr[n-1]);
      end
      ew = lead ? (ea[n] && !ev[n]) : (ea[n-1] && !ev[n-1]);
      chk(wait_flag == ew, lead ? "R6 lead wait" : "R6 coincident wait", wait_flag, ew);
    end
  endtask

  task automatic stop_and_check(input string tag);
    @(negedge clk); halt = 1'b1;
    @(negedge clk); halt = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!word_vld && !busy && !wait_flag, tag,
          {word_vld, busy, wait_flag}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [4];
    codes[0] = 3'b001; codes[1] = 3'b010; codes[2] = 3'b011; codes[3] = 3'b111;
    repeat (3) @(negedge clk);
    chk(!word_vld && !busy && !wait_flag, "R1 in reset", {word_vld, busy, wait_flag}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!word_vld && !busy && !wait_flag, "R1 after reset", {word_vld, busy, wait_flag}, 0);

    // sweep: all offsets, all length codes, both wrap settings, both WAIT modes
    for (int c = 0; c < 4; c++)
      for (int lin = 0; lin < 2; lin++)
        for (int ld = 0; ld < 2; ld++)
          for (int s = 0; s < 16; s++) begin
            run(AW'(16'h12F0 + s), codes[c], bit'(lin), bit'(ld), 48);
            if (codes[c] == 3'b111) stop_and_check("R8 halt continuous");
          end

    // reserved codes behave as continuous, wrap ignored (R2, R4)
    run(16'h00FD, 3'b000, 1'b0, 1'b1, 40);
    stop_and_check("R8 halt reserved code");
    run(16'h0206, 3'b101, 1'b0, 1'b0, 40);
    stop_and_check("R8 halt reserved code");

    // R8: halt in the middle of a fixed burst
    @(negedge clk);
    go = 1'b1; go_addr = 16'h0005; len_sel = 3'b011; linear_mode = 1'b1;
    @(negedge clk); go = 1'b0;
    repeat (5) @(negedge clk);
    stop_and_check("R8 halt fixed burst");

    // R9: restart during a continuous burst
    @(negedge clk);
    go = 1'b1; go_addr = 16'h0031; len_sel = 3'b111; linear_mode = 1'b1;
    @(negedge clk); go = 1'b0;
    repeat (6) @(negedge clk);
    chk(word_vld == 1'b1, "R9 first burst running", word_vld, 1);
    run(16'h0A0E, 3'b010, 1'b0, 1'b1, 20);
    run(16'h0A0B, 3'b011, 1'b1, 1'b0, 4);
    run(16'h0C03, 3'b001, 1'b1, 1'b1, 20);

    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule